// File: doc/BRIEF.md
# Pausable Refresh Scheduler

This block manages refresh for one rank of a memory controller. A free-running interval counter adds one owed refresh to a pending count every `REFI_CYC` controller cycles, and the count saturates at `MAX_PEND`. The scheduler trades those owed refreshes against demand reads, which it sees through a single "reads waiting for this rank" input. It drives the refresh-enable line to the device. It reports whether the refresh in flight is a deadline refresh, and it gives a one-cycle pulse when a refresh is retired.

A refresh that starts while the backlog is below the limit is opportunistic, and it can be interrupted. The refresh interval `RFC_CYC` is split into `PAUSE_PTS` equal quanta. If a read is waiting when a quantum ends, refresh-enable falls on that boundary and the rank is handed to reads. Once the read queue drains, refresh-enable rises again and the refresh continues. A progress timer counts only the cycles with refresh-enable high, so progress carries across any number of pauses. The refresh retires when the timer reaches `RFC_CYC`, and the pending count drops only at that point. When the backlog reaches `MAX_PEND`, the next refresh is a deadline refresh: it starts whatever the read queue holds, and it runs to the end without a pause.

Top module: `refresh_pause_sched`

## Requirements
- R1: The pending count starts at 0 after reset and rises by one at the clock edge that ends each span of `REFI_CYC` cycles, counted from reset release. It never exceeds `MAX_PEND`. A tick at `MAX_PEND` with no retirement on the same edge is dropped.
- R2: While no refresh is in flight, a new refresh starts (refresh-enable rises on the next edge) only when the pending count is non-zero and either `rd_waiting` is low or the count equals `MAX_PEND`. A waiting read with a count below `MAX_PEND` keeps refresh-enable low.
- R3: A refresh that starts with the pending count at `MAX_PEND` raises `ref_forced`. It keeps refresh-enable high for `RFC_CYC` consecutive cycles whatever `rd_waiting` does, and `ref_forced` drops together with refresh-enable when the refresh retires.
- R4: During an opportunistic refresh, if `rd_waiting` is high, refresh-enable falls on the edge where the accumulated refresh cycles reach the next multiple of `RFC_CYC/PAUSE_PTS`. It stays high until that edge.
- R5: Progress is held while paused. Refresh-enable is high for exactly `RFC_CYC` cycles in total per refresh, summed over all of its running spans. On the edge that ends the last of those cycles, refresh-enable falls, `ref_done` is high for one cycle, and the pending count drops by one (a tick on the same edge cancels the drop).
- R6: A paused refresh resumes, with refresh-enable rising on the next edge, once `rd_waiting` is low or the pending count reaches `MAX_PEND`. It can be paused and resumed again any number of times.
- R7: A synchronous active-high reset clears refresh-enable, `ref_forced`, `ref_done`, the pending count and all progress.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Controller clock |
| rst | input | 1 | Synchronous active-high reset |
| rd_waiting | input | 1 | Read queue for this rank is not empty |
| ref_en | output | 1 | Refresh-enable to the device (registered) |
| ref_forced | output | 1 | In-flight refresh is a deadline refresh and cannot pause |
| ref_done | output | 1 | One-cycle pulse when a refresh retires |
| pend_cnt | output | $clog2(MAX_PEND+1) | Number of owed refreshes |

## Verification
The checks watch `ref_en` through a refresh that has one pause, and through two back-to-back deadline refreshes. Suppose the progress timer lost or repeated a cycle across a pause. The retirement pulse and the drop in the pending count would then land on a different edge, shifted by at least one cycle from the expected retirement edge. A wrong quantum counter shows up as `ref_en` falling one or more edges away from the pause point. A wrong backlog count shows up at the first tick or deadline start that follows it, at most `REFI_CYC` cycles later, as a wrong `pend_cnt` or a deadline start on the wrong edge.

// File: rtl/rq_pkg.sv
package rq_pkg;
  typedef enum logic [1:0] {
    RQ_IDLE  = 2'd0,
    RQ_RUN   = 2'd1,
    RQ_PAUSE = 2'd2
  } rq_state_e;
endpackage

// File: rtl/rq_interval_tick.sv
module rq_interval_tick #(
  parameter int REFI_CYC = 3120
) (
  input  logic clk,
  input  logic rst,
  output logic tick
);
  localparam int TW = $clog2(REFI_CYC);

  logic [TW-1:0] cnt;

  assign tick = (cnt == TW'(REFI_CYC - 1));

  always_ff @(posedge clk) begin
    if (rst)       cnt <= '0;
    else if (tick) cnt <= '0;
    else           cnt <= cnt + 1'b1;
  end
endmodule

// File: rtl/rq_pend_count.sv
module rq_pend_count #(
  parameter int MAX_PEND = 8
) (
  input  logic                          clk,
  input  logic                          rst,
  input  logic                          inc,
  input  logic                          dec,
  output logic [$clog2(MAX_PEND+1)-1:0] cnt,
  output logic                          full
);
  localparam int CW = $clog2(MAX_PEND + 1);

  assign full = (cnt == CW'(MAX_PEND));

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt <= '0;
    end else if (inc && !dec && !full) begin
      cnt <= cnt + 1'b1;
    end else if (dec && !inc && cnt != '0) begin
      cnt <= cnt - 1'b1;
    end
  end

  AST_PEND_MAX: assert property (@(posedge clk) disable iff (rst)
    cnt <= CW'(MAX_PEND)); // R1
endmodule

// File: rtl/rq_progress.sv
module rq_progress #(
  parameter int RFC_CYC   = 280,
  parameter int PAUSE_PTS = 8
) (
  input  logic clk,
  input  logic rst,
  input  logic run,
  output logic at_point,
  output logic at_end
);
  localparam int RPC = RFC_CYC / PAUSE_PTS;
  localparam int TW  = $clog2(RFC_CYC + 1);
  localparam int QW  = $clog2(RPC + 1);

  logic [TW-1:0] timer;
  logic [QW-1:0] qcnt;

  assign at_end   = run && (timer == TW'(RFC_CYC - 1));
  assign at_point = run && (qcnt == QW'(RPC - 1));

  always_ff @(posedge clk) begin
    if (rst) begin
      timer <= '0;
      qcnt  <= '0;
    end else if (at_end) begin
      timer <= '0;
      qcnt  <= '0;
    end else if (run) begin
      timer <= timer + 1'b1;
      qcnt  <= at_point ? '0 : qcnt + 1'b1;
    end
  end

  AST_PAUSE_ON_POINT: assert property (@(posedge clk) disable iff (rst)
    ($fell(run) && !$past(at_end)) |-> (qcnt == '0)); // R4
  AST_TIMER_HOLD: assert property (@(posedge clk) disable iff (rst)
    (!run && timer != '0) |=> $stable(timer)); // R5
endmodule

// File: rtl/refresh_pause_sched.sv
module refresh_pause_sched #(
  parameter int REFI_CYC  = 3120,
  parameter int RFC_CYC   = 280,
  parameter int PAUSE_PTS = 8,
  parameter int MAX_PEND  = 8
) (
  input  logic                          clk,
  input  logic                          rst,
  input  logic                          rd_waiting,
  output logic                          ref_en,
  output logic                          ref_forced,
  output logic                          ref_done,
  output logic [$clog2(MAX_PEND+1)-1:0] pend_cnt
);
  import rq_pkg::*;

  rq_state_e state;
  logic      forced;
  logic      done_q;
  logic      tick;
  logic      full;
  logic      at_point;
  logic      at_end;
  logic      running;

  assign running = (state == RQ_RUN);

  rq_interval_tick #(.REFI_CYC(REFI_CYC)) i_tick (
    .clk(clk), .rst(rst), .tick(tick)
  );

  rq_pend_count #(.MAX_PEND(MAX_PEND)) i_pend (
    .clk(clk), .rst(rst), .inc(tick), .dec(at_end),
    .cnt(pend_cnt), .full(full)
  );

  rq_progress #(.RFC_CYC(RFC_CYC), .PAUSE_PTS(PAUSE_PTS)) i_prog (
    .clk(clk), .rst(rst), .run(running),
    .at_point(at_point), .at_end(at_end)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state  <= RQ_IDLE;
      forced <= 1'b0;
      done_q <= 1'b0;
    end else begin
      done_q <= 1'b0;
      unique case (state)
        RQ_IDLE: begin
          if (pend_cnt != '0 && (!rd_waiting || full)) begin
            state  <= RQ_RUN;
            forced <= full;
          end
        end
        RQ_RUN: begin
          if (at_end) begin
            state  <= RQ_IDLE;
            forced <= 1'b0;
            done_q <= 1'b1;
          end else if (at_point && rd_waiting && !forced && !full) begin
            state <= RQ_PAUSE;
          end else begin
            forced <= forced | full;
          end
        end
        RQ_PAUSE: begin
          if (!rd_waiting || full) begin
            state  <= RQ_RUN;
            forced <= full;
          end
        end
        default: state <= RQ_IDLE;
      endcase
    end
  end

  assign ref_en     = running;
  assign ref_forced = forced;
  assign ref_done   = done_q;

  AST_READ_HOLDS_OFF: assert property (@(posedge clk) disable iff (rst)
    (state == RQ_IDLE && rd_waiting && !full) |=> !ref_en); // R2
  AST_FORCED_NO_PAUSE: assert property (@(posedge clk) disable iff (rst)
    (ref_en && ref_forced) |=> (ref_en || ref_done)); // R3
  AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
    ref_done |=> !ref_done); // R5
  AST_RESUME_ON_EMPTY: assert property (@(posedge clk) disable iff (rst)
    (state == RQ_PAUSE && !rd_waiting) |=> ref_en); // R6
endmodule

// File: tb/test_refresh_pause_sched.sv
`timescale 1ns/100ps
module test_refresh_pause_sched;
  localparam int REFI = 40;
  localparam int RFC  = 24;
  localparam int NPTS = 4;
  localparam int MAXP = 8;
  localparam int NVEC = 21;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       rd  = 1'b1;
  logic       en, forced, done;
  logic [3:0] pend;

  int checks   = 0;
  int failures = 0;
  bit finished = 1'b0;

  always #2.5 clk = ~clk;

  refresh_pause_sched #(
    .REFI_CYC(REFI), .RFC_CYC(RFC), .PAUSE_PTS(NPTS), .MAX_PEND(MAXP)
  ) i_refresh_pause_sched (
    .clk(clk), .rst(rst), .rd_waiting(rd),
    .ref_en(en), .ref_forced(forced), .ref_done(done), .pend_cnt(pend)
  );

  // {rd, cycles, exp en, exp forced, exp done, exp pend}
  localparam logic [23:0] VEC [NVEC] = '{
    {1'b1, 16'd40,  1'b0, 1'b0, 1'b0, 4'd1},
    {1'b1, 16'd5,   1'b0, 1'b0, 1'b0, 4'd1},
    {1'b0, 16'd1,   1'b1, 1'b0, 1'b0, 4'd1},
    {1'b0, 16'd3,   1'b1, 1'b0, 1'b0, 4'd1},
    {1'b1, 16'd2,   1'b1, 1'b0, 1'b0, 4'd1},
    {1'b1, 16'd1,   1'b0, 1'b0, 1'b0, 4'd1},
    {1'b1, 16'd10,  1'b0, 1'b0, 1'b0, 4'd1},
    {1'b0, 16'd1,   1'b1, 1'b0, 1'b0, 4'd1},
    {1'b0, 16'd17,  1'b1, 1'b0, 1'b0, 4'd2},
    {1'b0, 16'd1,   1'b0, 1'b0, 1'b1, 4'd1},
    {1'b1, 16'd1,   1'b0, 1'b0, 1'b0, 4'd1},
    {1'b1, 16'd237, 1'b0, 1'b0, 1'b0, 4'd6},
    {1'b1, 16'd1,   1'b0, 1'b0, 1'b0, 4'd7},
    {1'b1, 16'd40,  1'b0, 1'b0, 1'b0, 4'd8},
    {1'b1, 16'd1,   1'b1, 1'b1, 1'b0, 4'd8},
    {1'b1, 16'd10,  1'b1, 1'b1, 1'b0, 4'd8},
    {1'b1, 16'd13,  1'b1, 1'b1, 1'b0, 4'd8},
    {1'b1, 16'd1,   1'b0, 1'b0, 1'b1, 4'd7},
    {1'b1, 16'd15,  1'b0, 1'b0, 1'b0, 4'd8},
    {1'b1, 16'd1,   1'b1, 1'b1, 1'b0, 4'd8},
    {1'b1, 16'd24,  1'b0, 1'b0, 1'b1, 4'd7}
  };

  function automatic string tag_of(int i);
    case (i)
      0, 8, 11, 12, 13, 18: return "R1";
      1, 2, 10:             return "R2";
      14, 15, 16, 17, 19:   return "R3";
      4, 5:                 return "R4";
      7:                    return "R6";
      default:              return "R5";
    endcase
  endfunction

  task automatic step(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic chk(input string tag, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  task automatic chk_all(input string tag, input int e_en, input int e_f,
                         input int e_d, input int e_p);
    chk(tag, "ref_en", en, e_en);
    chk(tag, "ref_forced", forced, e_f);
    chk(tag, "ref_done", done, e_d);
    chk(tag, "pend_cnt", pend, e_p);
  endtask

  initial begin
    step(3);
    chk_all("R7", 0, 0, 0, 0);
    rst = 1'b0;
    for (int i = 0; i < NVEC; i++) begin
      rd = VEC[i][23];
      step(int'(VEC[i][22:7]));
      chk_all(tag_of(i), VEC[i][6], VEC[i][5], VEC[i][4], VEC[i][3:0]);
    end

    // R7: reset in the middle of operation
    rst = 1'b1;
    step(2);
    chk_all("R7", 0, 0, 0, 0);
    rst = 1'b0;
    rd  = 1'b0;
    step(40);
    chk_all("R1", 0, 0, 0, 1);
    step(1);
    chk_all("R2", 1, 0, 0, 1);
    // R4 then R6: pause, resume, pause again
    rd = 1'b1;
    step(5);
    chk("R4", "ref_en before point", en, 1);
    step(1);
    chk("R4", "ref_en at point", en, 0);
    rd = 1'b0;
    step(1);
    chk("R6", "ref_en resumed", en, 1);
    rd = 1'b1;
    step(5);
    chk("R6", "ref_en before second point", en, 1);
    step(1);
    chk("R6", "ref_en second pause", en, 0);
    chk("R6", "pend_cnt while paused", pend, 1);

    finished = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!finished) begin
      failures++;
      checks++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule